// File: doc/BRIEF.md
# Input Pre-Bias Sink Controller

This block decides when a dummy sink load on the charger input is switched on. Some supplies regulate properly only with a minimum load on them, so their unloaded output can sit just above the input overvoltage limit. When the input lies between the normal overvoltage threshold and a higher, pre-bias overvoltage threshold, the sink is turned on to pull the input back into the valid range. The block works from two digitized comparator flags for those thresholds, the charger's phase code, an automatic-shutdown flag, a function enable and a one-millisecond tick.

The input has to stay inside the window for a qualification time before the sink is armed. After that a sticky activation flag holds the sink armed, even once the input has been pulled below the normal threshold. The sink is on only while the charger phase is one that allows it: idle, trickle charge or taper charge. Automatic shutdown forces the sink off at once. Two status outputs report that activation has happened and whether the sink is on now.

Top module: `prebias_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, sink_en_o, act_seen_o and sink_live_o are 0.
- R2: The window is open when vin_over_i is 1 and vin_over_hi_i is 0. Ticks that arrive while the window is closed never cause activation.
- R3: act_seen_o rises on the clock edge that samples the QUAL_TICKS-th tick (default 5) seen with the window open and func_en_i high without a break. A closed window before that tick sets the count back to zero.
- R4: Once set, act_seen_o stays 1 after vin_over_i falls to 0, as long as vin_over_hi_i stays 0 and func_en_i stays 1.
- R5: A cycle with vin_over_hi_i at 1 or func_en_i at 0 clears act_seen_o on the next edge.
- R6: The sink can be on only when activation is in force and phase_i is one of the allowed codes 0 (idle), 1 (trickle) or 4 (taper). Codes 2 (pre-charge), 3 (fast), 5 (done), 6 (fault) and 7 turn it off on the next edge.
- R7: auto_off_i at 1 turns the sink off on the next edge and does not clear act_seen_o.
- R8: With func_en_i at 0, no activation takes place and the sink stays off, whatever the window and the ticks do.
- R9: sink_en_o and sink_live_o are registered. After any input change they take their new value one edge later, and they are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vin_over_i | input | 1 | Input above the normal overvoltage threshold |
| vin_over_hi_i | input | 1 | Input above the pre-bias overvoltage threshold |
| phase_i | input | STATE_W | Charger phase code |
| auto_off_i | input | 1 | Automatic-shutdown condition present |
| func_en_i | input | 1 | Pre-bias function enable |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| sink_en_o | output | 1 | Drive enable for the input sink |
| act_seen_o | output | 1 | Sticky flag: activation has occurred |
| sink_live_o | output | 1 | Sink is on at this moment |

## Verification
The window is driven in four combinations of the two comparator flags. Only the one that opens the window may advance the qualification, so the window decode is checked apart from the tick counting. Short stays of fewer ticks, with a break in between, separate a restarting count from an accumulating one. A full stay shows that activation comes on exactly the expected tick. With activation in force, a sweep over all eight phase codes, an automatic-shutdown pulse, the upper-threshold flag and the enable toggle separate a veto that only gates the sink from one that also clears the sticky flag.

// File: rtl/prebias_pkg.sv
package prebias_pkg;
   // Charger phase codes seen on phase_i
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_TRICKLE = 3'd1,
      PH_PRECHG  = 3'd2,
      PH_FAST    = 3'd3,
      PH_TAPER   = 3'd4,
      PH_DONE    = 3'd5,
      PH_FAULT   = 3'd6,
      PH_RSVD    = 3'd7
   } phase_e;

   // Phases in which an activated sink may conduct: idle, trickle, taper
   localparam logic [7:0] DEF_ALLOW = (8'd1 << PH_IDLE) | (8'd1 << PH_TRICKLE)
                                    | (8'd1 << PH_TAPER);
   localparam int unsigned DEF_QUAL_TICKS = 5;
endpackage

// File: rtl/prebias_qual.sv
module prebias_qual #(
   parameter int unsigned QUAL_TICKS = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic tick_i,
   output logic hit_o
);
   generate
      if (QUAL_TICKS < 1) begin : g_bad_qual
         $error("prebias_qual: QUAL_TICKS must be at least 1");
      end

      if (QUAL_TICKS == 1) begin : g_single
         // One tick inside the window suffices: no counter
         assign hit_o = arm_i & tick_i;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(QUAL_TICKS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             full;

         assign full  = (cnt_q == LAST);
         assign hit_o = arm_i & tick_i & full;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (!arm_i) begin
               cnt_q <= '0;
            end else if (tick_i && !full) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/prebias_gate.sv
module prebias_gate #(
   parameter int unsigned STATE_W = 3,
   parameter logic [(1<<STATE_W)-1:0] ALLOW_MASK = '1
) (
   input  logic [STATE_W-1:0] phase_i,
   output logic               allow_o
);
   localparam int unsigned NCODE = 1 << STATE_W;

   logic [NCODE-1:0] hot;

   generate
      for (genvar c = 0; c < NCODE; c++) begin : g_code
         assign hot[c] = (phase_i == STATE_W'(c)) & ALLOW_MASK[c];
      end
   endgenerate

   assign allow_o = |hot;
endmodule

// File: rtl/prebias_ctrl.sv
module prebias_ctrl
   import prebias_pkg::*;
#(
   parameter int unsigned STATE_W    = 3,
   parameter int unsigned QUAL_TICKS = DEF_QUAL_TICKS,
   parameter logic [(1<<STATE_W)-1:0] ALLOW_MASK = (1<<STATE_W)'(DEF_ALLOW)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               vin_over_i,
   input  logic               vin_over_hi_i,
   input  logic [STATE_W-1:0] phase_i,
   input  logic               auto_off_i,
   input  logic               func_en_i,
   input  logic               tick_ms_i,
   output logic               sink_en_o,
   output logic               act_seen_o,
   output logic               sink_live_o
);
   generate
      if (STATE_W < 1 || STATE_W > 4) begin : g_bad_w
         $error("prebias_ctrl: STATE_W must be 1 to 4");
      end
      if (ALLOW_MASK == '0) begin : g_bad_mask
         $error("prebias_ctrl: ALLOW_MASK enables no phase");
      end
   endgenerate

   logic win, arm, hit, allow;
   logic act_q, act_d, sink_q, sink_d;

   assign win = vin_over_i & ~vin_over_hi_i;
   assign arm = win & func_en_i;

   prebias_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm),
      .tick_i (tick_ms_i),
      .hit_o  (hit)
   );

   prebias_gate #(.STATE_W(STATE_W), .ALLOW_MASK(ALLOW_MASK)) u_gate (
      .phase_i (phase_i),
      .allow_o (allow)
   );

   always_comb begin
      act_d = act_q;
      if (!func_en_i || vin_over_hi_i) begin
         act_d = 1'b0;
      end else if (hit) begin
         act_d = 1'b1;
      end
      sink_d = act_d & func_en_i & ~auto_off_i & allow;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q  <= 1'b0;
         sink_q <= 1'b0;
      end else begin
         act_q  <= act_d;
         sink_q <= sink_d;
      end
   end

   assign sink_en_o   = sink_q;
   assign sink_live_o = sink_q;
   assign act_seen_o  = act_q;
endmodule

// File: rtl/prebias_chk.sv
module prebias_chk #(
   parameter int unsigned STATE_W = 3,
   parameter logic [(1<<STATE_W)-1:0] ALLOW_MASK = '1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               vin_over_i,
   input logic               vin_over_hi_i,
   input logic [STATE_W-1:0] phase_i,
   input logic               auto_off_i,
   input logic               func_en_i,
   input logic               tick_ms_i,
   input logic               sink_en_o,
   input logic               act_seen_o,
   input logic               sink_live_o
);
   // R3 / R2: activation only rises on a tick taken inside the open window
   p_rise_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_seen_o) |-> $past(tick_ms_i && vin_over_i && !vin_over_hi_i && func_en_i));

   // R4: sticky while neither clearing condition is present
   p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_seen_o && func_en_i && !vin_over_hi_i) |=> act_seen_o);

   // R5: upper threshold clears the activation
   p_hi_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vin_over_hi_i |=> !act_seen_o);

   // R6: disallowed phase turns the sink off
   p_phase_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ALLOW_MASK[phase_i] |=> !sink_en_o);

   // R6: sink never conducts without activation
   p_sink_needs_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sink_en_o |-> act_seen_o);

   // R7: automatic shutdown vetoes the sink
   p_auto_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      auto_off_i |=> !sink_en_o);

   // R8: disabled function leaves everything off
   p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !func_en_i |=> (!sink_en_o && !act_seen_o));

   // R9: live status tracks the drive
   p_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sink_en_o) |-> $rose(sink_live_o));
endmodule

bind prebias_ctrl prebias_chk #(.STATE_W(STATE_W), .ALLOW_MASK(ALLOW_MASK)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .vin_over_i    (vin_over_i),
   .vin_over_hi_i (vin_over_hi_i),
   .phase_i       (phase_i),
   .auto_off_i    (auto_off_i),
   .func_en_i     (func_en_i),
   .tick_ms_i     (tick_ms_i),
   .sink_en_o     (sink_en_o),
   .act_seen_o    (act_seen_o),
   .sink_live_o   (sink_live_o)
);

// File: tb/sim_prebias_ctrl.sv
`timescale 1ns/1ps
module sim_prebias_ctrl;
   localparam int QUAL = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ov = 1'b0, ovh = 1'b0, aoff = 1'b0, en = 1'b1, tick = 1'b0;
   logic [2:0] ph = 3'd0;
   logic       sink, act, live;

   int errors = 0, checks = 0;
   string cur = "R1";
   bit done = 1'b0;

   // reference state
   int m_ticks = 0;
   bit m_act = 1'b0, m_sink = 1'b0;

   always #2 clk = ~clk;

   prebias_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .vin_over_i(ov), .vin_over_hi_i(ovh),
      .phase_i(ph), .auto_off_i(aoff), .func_en_i(en), .tick_ms_i(tick),
      .sink_en_o(sink), .act_seen_o(act), .sink_live_o(live)
   );

   function automatic bit phase_ok(input logic [2:0] p);
      return (p == 3'd0) || (p == 3'd1) || (p == 3'd4);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ticks = 0; m_act = 0; m_sink = 0;
      end else begin
         if (!en || ovh) begin
            m_ticks = 0; m_act = 0;
         end else if (!ov) begin
            m_ticks = 0;
         end else if (tick) begin
            m_ticks = m_ticks + 1;
            if (m_ticks >= QUAL) m_act = 1;
         end
         m_sink = m_act && en && !aoff && phase_ok(ph);
      end
   end

   task automatic chk(input string req, input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
      chk(cur, act,  m_act,  "act_seen_o");
      chk(cur, sink, m_sink, "sink_en_o");
      chk("R9", live, sink, "sink_live_o");
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; step();
         tick = 1'b0; step(); step();
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", act, 1'b0, "act in reset");
      chk("R1", sink, 1'b0, "sink in reset");
      chk("R1", live, 1'b0, "live in reset");
      rst_n = 1'b1;
      step();
      chk("R1", sink, 1'b0, "sink after reset");

      // R2: closed window in both ways, ticks never activate
      cur = "R2"; ov = 1'b0; ovh = 1'b0; ticks(QUAL + 2);
      ov = 1'b1; ovh = 1'b1; ticks(QUAL + 2);
      chk("R2", act, 1'b0, "no activation above upper threshold");
      ovh = 1'b0;

      // R3: short stays with breaks restart the count
      cur = "R3"; ticks(QUAL - 1); ov = 1'b0; step(); ov = 1'b1;
      ticks(QUAL - 1);
      chk("R3", act, 1'b0, "count restarted after break");
      ov = 1'b0; step(); ov = 1'b1;
      ticks(QUAL - 1);
      tick = 1'b1; step();
      chk("R3", act, 1'b1, "activation on final tick");
      chk("R6", sink, 1'b1, "sink on in idle phase");
      tick = 1'b0; step();

      // R4: sink pulls input down, flag stays
      cur = "R4"; ov = 1'b0; repeat (20) step();
      chk("R4", act, 1'b1, "sticky after window left");

      // R6: phase sweep
      cur = "R6";
      for (int p = 0; p < 8; p++) begin
         ph = 3'(p); step();
         chk("R6", sink, phase_ok(3'(p)), "sink per phase");
      end
      ph = 3'd1; step();

      // R7: automatic shutdown
      cur = "R7"; aoff = 1'b1; step();
      chk("R7", sink, 1'b0, "sink off in auto shutdown");
      chk("R7", act, 1'b1, "flag kept in auto shutdown");
      aoff = 1'b0; step();
      chk("R7", sink, 1'b1, "sink back after auto shutdown");

      // R5: upper threshold clears
      cur = "R5"; ov = 1'b1; ovh = 1'b1; step();
      chk("R5", act, 1'b0, "cleared by upper threshold");
      ovh = 1'b0; ph = 3'd4; ticks(QUAL);
      chk("R3", act, 1'b1, "reactivated in taper");
      cur = "R5"; en = 1'b0; step();
      chk("R5", act, 1'b0, "cleared by disable");

      // R8: disabled, window open, plenty of ticks
      cur = "R8"; ticks(QUAL * 3);
      chk("R8", sink, 1'b0, "disabled sink off");
      chk("R8", act, 1'b0, "disabled no activation");
      en = 1'b1; ticks(QUAL); step();

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule